// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block keeps the program counter of a single-cycle processor and works out, on every clock, the address of the next instruction to fetch. The current counter value drives the instruction memory address; the counter plus one instruction step (4 bytes) is also brought out so that other logic can use it.

Each cycle the sequencer picks one of three candidates. The sequential address is the counter plus 4. The conditional-branch target adds a word-scaled, sign-extended 16-bit displacement taken from the instruction to that sequential address. The absolute jump target keeps the top four bits of the sequential address and fills the rest from a 26-bit instruction field scaled to words. The decoder supplies a branch flag and a jump flag. The ALU supplies its zero flag, which is set when the two compared operands are equal. A jump overrides everything else. A branch is taken only when the branch flag and the zero flag are both set.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0x00000000. Asserting `rst_n` clears it at once, without waiting for a clock edge.
- R2: `pc_plus4` always equals `pc_q + 4`, modulo 2^32.
- R3: With `jump_en` and `branch_en` both low, every rising clock edge loads `pc_q` with its previous value plus 4. There is no load enable.
- R4: With `branch_en` = 1, `alu_zero` = 1 and `jump_en` = 0, the next `pc_q` is `pc_plus4` plus (`instr_word[15:0]` sign-extended from bit 15, times 4).
- R5: With `branch_en` = 1 and `alu_zero` = 0, the next `pc_q` is the sequential address `pc_plus4`.
- R6: When `instr_word[15]` = 1 and the branch is taken, the target lies below `pc_plus4` by (65536 − `instr_word[15:0]`) × 4, modulo 2^32.
- R7: With `jump_en` = 1, the next `pc_q` is {`pc_plus4[31:28]`, `instr_word[25:0]`, 2'b00}, whatever `branch_en` and `alu_zero` are.
- R8: `alu_zero` = 1 with `branch_en` = 0 has no effect: the next `pc_q` is `pc_plus4`.
- R9: Address arithmetic wraps modulo 2^32. A step from 0xFFFFFFFC gives 0x00000000, and a negative branch offset from a low address gives a high address.
- R10: The top four bits of a jump target come from `pc_plus4`, not from `pc_q`. A jump at `pc_q` = 0xFFFFFFFC therefore lands in region 0x0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter loads on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_word | input | 32 | Instruction word fetched at `pc_q` |
| branch_en | input | 1 | Decoder flag: the instruction is a conditional branch on equality |
| jump_en | input | 1 | Decoder flag: the instruction is an absolute jump |
| alu_zero | input | 1 | ALU zero flag; 1 when the compared operands are equal |
| pc_q | output | 32 | Current program counter, the instruction memory address |
| pc_plus4 | output | 32 | Sequential next address, `pc_q + 4` |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit displacement, a 4-bit region field and a 4-byte step. With these values a single negative branch from address 0 reaches the top of the address space, and the next step wraps back to zero. The same values also allow a jump issued at 0xFFFFFFFC, where the region nibble of `pc_q` and that of `pc_plus4` differ, so that case is covered. A long pseudo-random run of mixed branch, jump and flag patterns then moves the counter across many regions. On every cycle it is compared against an integer model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Source chosen for the next fetch address
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2
  } nxt_sel_e;

endpackage

// File: rtl/pcs_incrementer.sv
module pcs_incrementer #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] sum_o
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  // Modulo-2^ADDR_W add; the carry out is dropped
  always_comb begin
    sum_o = pc_i + STEP_V;
  end

endmodule

// File: rtl/pcs_branch_target.sv
module pcs_branch_target #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] tgt_o
);

  localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

  logic [ADDR_W-1:0] disp;

  // Sign-extend the displacement and scale it to bytes
  always_comb begin
    disp  = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {SHIFT{1'b0}}};
    tgt_o = base_i + disp;
  end

endmodule

// File: rtl/pcs_jump_target.sv
module pcs_jump_target #(
  parameter int ADDR_W  = 32,
  parameter int UPPER_W = 4,
  parameter int SHIFT   = 2
) (
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic [ADDR_W-UPPER_W-SHIFT-1:0]   field_i,
  output logic [ADDR_W-1:0]                 tgt_o
);

  // Keep the region bits of the base, replace the rest from the field
  always_comb begin
    tgt_o = {base_i[ADDR_W-1 -: UPPER_W], field_i, {SHIFT{1'b0}}};
  end

endmodule

// File: rtl/pcs_next_select.sv
module pcs_next_select
  import pcs_pkg::*;
(
  input  logic     branch_en_i,
  input  logic     jump_en_i,
  input  logic     zero_i,
  output nxt_sel_e sel_o
);

  // Jump has priority; a branch needs the equality flag
  always_comb begin
    if (jump_en_i) begin
      sel_o = NXT_JUMP;
    end else if (branch_en_i && zero_i) begin
      sel_o = NXT_BRANCH;
    end else begin
      sel_o = NXT_SEQ;
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              INSTR_W    = 32,
  parameter int              OFF_W      = 16,
  parameter int              UPPER_W    = 4,
  parameter int              STEP       = 4,
  parameter logic [31:0]     RESET_ADDR = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  instr_word,
  input  logic                branch_en,
  input  logic                jump_en,
  input  logic                alu_zero,
  output logic [ADDR_W-1:0]   pc_q,
  output logic [ADDR_W-1:0]   pc_plus4
);

  localparam int SHIFT    = $clog2(STEP);
  localparam int JFIELD_W = ADDR_W - UPPER_W - SHIFT;
  localparam int EXT_W    = ADDR_W - OFF_W - SHIFT;

  logic [ADDR_W-1:0] pc_r;
  logic [ADDR_W-1:0] pc_nxt;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;
  nxt_sel_e          sel;
  logic              unused_opcode_bits;

  assign unused_opcode_bits = ^instr_word[INSTR_W-1:JFIELD_W];

  pcs_incrementer #(
    .ADDR_W (ADDR_W),
    .STEP   (STEP)
  ) u_inc (
    .pc_i  (pc_r),
    .sum_o (seq_addr)
  );

  pcs_branch_target #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT)
  ) u_btgt (
    .base_i   (seq_addr),
    .offset_i (instr_word[OFF_W-1:0]),
    .tgt_o    (br_addr)
  );

  pcs_jump_target #(
    .ADDR_W  (ADDR_W),
    .UPPER_W (UPPER_W),
    .SHIFT   (SHIFT)
  ) u_jtgt (
    .base_i  (seq_addr),
    .field_i (instr_word[JFIELD_W-1:0]),
    .tgt_o   (jmp_addr)
  );

  pcs_next_select u_sel (
    .branch_en_i (branch_en),
    .jump_en_i   (jump_en),
    .zero_i      (alu_zero),
    .sel_o       (sel)
  );

  // Next-state process
  always_comb begin
    unique case (sel)
      NXT_JUMP:   pc_nxt = jmp_addr;
      NXT_BRANCH: pc_nxt = br_addr;
      default:    pc_nxt = seq_addr;
    endcase
  end

  // Register process: loads on every edge, no enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_r <= ADDR_W'(RESET_ADDR);
    end else begin
      pc_r <= pc_nxt;
    end
  end

  assign pc_q     = pc_r;
  assign pc_plus4 = seq_addr;

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && !branch_en) |=> (pc_q == $past(pc_q) + ADDR_W'(STEP)));

  // R5
  br_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && branch_en && !alu_zero) |=> (pc_q == $past(pc_plus4)));

  // R4
  br_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && branch_en && alu_zero) |=>
      (pc_q == $past(pc_q) + ADDR_W'(STEP) +
        {{EXT_W{$past(instr_word[OFF_W-1])}}, $past(instr_word[OFF_W-1:0]), {SHIFT{1'b0}}}));

  // R7
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_en |=> ((pc_q[SHIFT-1:0] == '0) &&
                 (pc_q[SHIFT +: JFIELD_W] == $past(instr_word[JFIELD_W-1:0]))));

  // R10
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_en |=> (pc_q[ADDR_W-1 -: UPPER_W] == $past(pc_plus4[ADDR_W-1 -: UPPER_W])));

  // R8
  zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && !branch_en && alu_zero) |=> (pc_q == $past(pc_plus4)));

endmodule

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr_word;
  logic        branch_en;
  logic        jump_en;
  logic        alu_zero;
  logic [31:0] pc_q;
  logic [31:0] pc_plus4;

  int unsigned vectors;
  int unsigned miscompares;
  bit          done;
  logic [31:0] model_pc;
  logic [31:0] rng;

  pc_sequencer i_pc_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_word (instr_word),
    .branch_en  (branch_en),
    .jump_en    (jump_en),
    .alu_zero   (alu_zero),
    .pc_q       (pc_q),
    .pc_plus4   (pc_plus4)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference: integer arithmetic, masked to 32 bits
  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic b, input logic j, input logic z);
    longint seq, off, t;
    seq = (longint'(pc) + 4) % 64'h1_0000_0000;
    if (j) begin
      t = (seq / 268435456) * 268435456 + longint'(ins % 32'h0400_0000) * 4;
    end else if (b && z) begin
      off = longint'(ins & 32'hFFFF);
      if (off >= 32768) off = off - 65536;
      t = seq + off * 4;
      t = ((t % 64'h1_0000_0000) + 64'h1_0000_0000) % 64'h1_0000_0000;
    end else begin
      t = seq;
    end
    return t[31:0];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic apply(input logic [31:0] ins, input logic b, input logic j,
                       input logic z, input string req);
    logic [31:0] exp;
    instr_word = ins;
    branch_en  = b;
    jump_en    = j;
    alu_zero   = z;
    exp = ref_next(model_pc, ins, b, j, z);
    @(posedge clk);
    @(negedge clk);
    model_pc = exp;
    check(pc_q, exp, req);
    check(pc_plus4, exp + 32'd4, "R2");
  endtask

  function automatic logic [31:0] xorshift(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  initial begin
    vectors     = 0;
    miscompares = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    instr_word  = '0;
    branch_en   = 1'b0;
    jump_en     = 1'b0;
    alu_zero    = 1'b0;
    model_pc    = '0;
    rng         = 32'h1357_9BDF;

    repeat (3) @(negedge clk);
    check(pc_q, 32'h0, "R1");
    check(pc_plus4, 32'h4, "R2");
    rst_n = 1'b1;

    // R3: consecutive sequential steps
    apply(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, "R3");
    apply(32'h0000_0000, 1'b0, 1'b0, 1'b0, "R3");
    apply(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R3");
    // R4: forward branch, offset 3 -> +12
    apply(32'h1000_0003, 1'b1, 1'b0, 1'b1, "R4");
    // R5: branch flag with operands unequal
    apply(32'h1000_0100, 1'b1, 1'b0, 1'b0, "R5");
    // R8: zero flag alone
    apply(32'h0000_0100, 1'b0, 1'b0, 1'b1, "R8");
    // R7: jump overrides a taken branch
    apply(32'h0800_0040, 1'b1, 1'b1, 1'b1, "R7");
    // R6: negative displacement 0xFFFE -> -8 from pc+4
    apply(32'h1000_FFFE, 1'b1, 1'b0, 1'b1, "R6");
    if (!(model_pc < 32'h0000_0104)) begin
      miscompares++;
      $display("FAIL R6: actual %08h expected below %08h", model_pc, 32'h104);
    end
    // R9: jump to 0, branch back to top, step wraps to zero
    apply(32'h0800_0000, 1'b0, 1'b1, 1'b0, "R7");
    apply(32'h1000_FFFE, 1'b1, 1'b0, 1'b1, "R9");
    check(pc_q, 32'hFFFF_FFFC, "R9");
    // R10: jump at 0xFFFFFFFC uses region of pc+4 (0x0)
    apply(32'h0800_0123, 1'b0, 1'b1, 1'b0, "R10");
    check(pc_q, 32'h0000_048C, "R10");
    // Reach 0xFFFFFFF8, then jump into region 0xF
    apply(32'h0800_0000, 1'b0, 1'b1, 1'b0, "R7");
    apply(32'h1000_FFFD, 1'b1, 1'b0, 1'b1, "R6");
    check(pc_q, 32'hFFFF_FFF8, "R9");
    apply(32'h0800_0123, 1'b0, 1'b1, 1'b0, "R10");
    check(pc_q, 32'hF000_048C, "R10");
    // Plain wrap by stepping
    apply(32'h0BFF_FFFF, 1'b0, 1'b1, 1'b0, "R7");
    apply(32'h0, 1'b0, 1'b0, 1'b0, "R9");
    check(pc_q, 32'h0000_0000, "R9");

    // Mixed pseudo-random run
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins;
      rng = xorshift(rng);
      ins = xorshift(rng ^ 32'hA5A5_5A5A);
      unique case (rng[1:0])
        2'd0: apply(ins, 1'b0, 1'b0, 1'b0, "R3");
        2'd1: apply(ins, 1'b1, 1'b0, rng[8], rng[8] ? "R4" : "R5");
        2'd2: apply(ins, rng[9], 1'b1, rng[10], "R7");
        default: apply(ins, 1'b0, 1'b0, 1'b1, "R8");
      endcase
    end

    // R1: asynchronous reset mid-cycle
    rst_n = 1'b0;
    #1;
    check(pc_q, 32'h0, "R1");
    @(negedge clk);
    check(pc_q, 32'h0, "R1");
    model_pc = '0;
    rst_n = 1'b1;
    apply(32'h0, 1'b0, 1'b0, 1'b0, "R3");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule